// File: doc/BRIEF.md
# Multi-Width Unsigned Multiply Execution Unit

This unit carries out an accumulator-style unsigned multiply for operand sizes of 8, 16, 32 and 64 bits. The register file supplies the current accumulator and data register values together with the source operand. Decoded opcode and prefix bits pick the operand size. A one-cycle start strobe launches the operation. The unit forms the double-width product with a shift-and-add loop that retires one multiplier bit per clock. It then returns new accumulator and data register values, a write enable for each register, and the carry and overflow flags, all qualified by a one-cycle done pulse.

Where the product goes depends on the size. For the byte form the whole 16-bit product goes into the low half-word of the accumulator. For the wider forms the low half goes to the accumulator and the high half to the data register. A byte-form request that carries a REX prefix and names one of the legacy high-byte registers as its source is refused. The unit flags it and starts nothing.

Top module: `umul_xu`

## Requirements
- R1: Byte size (`opc_w`=0): the product of `acc_in[7:0]` and `src_in[7:0]` appears in `acc_out[15:0]` and `acc_out[63:16]` equals `acc_in[63:16]`. `dat_we` is 0 and `dat_out` equals `dat_in`.
- R2: Word size: the product of the two 16-bit operands is split. The low 16 bits go to `acc_out[15:0]` and the high 16 bits to `dat_out[15:0]`. Bits 63:16 of both registers keep their input values. `dat_we` is 1.
- R3: Doubleword size: the low 32 product bits go to `acc_out[31:0]` and the high 32 bits to `dat_out[31:0]`. Bits 63:32 of both outputs are zero.
- R4: Quadword size: `acc_out` holds product bits 63:0 and `dat_out` holds product bits 127:64.
- R5: `cf` and `of` are both 1 when the upper half of the product is nonzero and both 0 otherwise. `flags_we` and `acc_we` are 1 exactly in the done cycle. No other flag is written.
- R6: Size decode works as follows. `opc_w`=0 selects 8 bits. With `opc_w`=1, `rex_w`=1 selects 64 bits regardless of `osz_ovr`. Otherwise `osz_ovr`=1 selects 16 bits and `osz_ovr`=0 selects 32 bits.
- R7: A start with `opc_w`=0, `rex_pres`=1 and `src_hi8`=1 pulses `illegal` for one cycle, one clock after the start edge. It launches no operation, so `busy` and `done` stay 0.
- R8: An accepted start raises `busy` at the next edge. `done` is high for exactly one cycle, N clock edges after the start edge, where N is the operand width in bits.
- R9: A start strobe seen while `busy` is 1 is ignored: the running operation finishes with its own results and timing.
- R10: Synchronous active-high `rst` returns the unit to idle, with `busy`, `done` and `illegal` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch strobe, one cycle |
| opc_w | input | 1 | 0 = byte form, 1 = word/dword/qword form |
| osz_ovr | input | 1 | Operand-size override prefix present |
| rex_w | input | 1 | REX.W set |
| rex_pres | input | 1 | Any REX prefix present |
| src_hi8 | input | 1 | Byte source field names a legacy high-byte register |
| acc_in | input | 64 | Current accumulator value |
| dat_in | input | 64 | Current data register value |
| src_in | input | 64 | Source operand value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Results valid, one cycle |
| illegal | output | 1 | Refused request, one cycle |
| acc_out | output | 64 | New accumulator value |
| dat_out | output | 64 | New data register value |
| acc_we | output | 1 | Accumulator write enable |
| dat_we | output | 1 | Data register write enable |
| flags_we | output | 1 | Write enable for CF and OF only |
| cf | output | 1 | Carry flag result |
| of | output | 1 | Overflow flag result |

## Verification
The assertions assume `start` is a single-cycle strobe. They also assume every request field is driven to a known value whenever `start` is high. The byte-flag property assumes that a done cycle with `dat_we` low always belongs to a byte operation. The stimulus holds `start` for exactly one cycle and sets the decode bits and operands together with it. It drives the strobe during `busy` only in the test of the ignored start, and it asserts reset in the middle of an operation only once.

// File: rtl/umul_xu.sv
module umul_xu (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        opc_w,
  input  logic        osz_ovr,
  input  logic        rex_w,
  input  logic        rex_pres,
  input  logic        src_hi8,
  input  logic [63:0] acc_in,
  input  logic [63:0] dat_in,
  input  logic [63:0] src_in,
  output logic        busy,
  output logic        done,
  output logic        illegal,
  output logic [63:0] acc_out,
  output logic [63:0] dat_out,
  output logic        acc_we,
  output logic        dat_we,
  output logic        flags_we,
  output logic        cf,
  output logic        of
);
  localparam int XW = 64;
  localparam int PW = 2 * XW;
  localparam int CW = $clog2(XW) + 1;

  logic [1:0]    sz_d, sz_q;
  logic          bad_req;
  logic [XW-1:0] opmask;
  logic [CW-1:0] width_d, cnt;
  logic [PW-1:0] mcand, prod;
  logic [XW-1:0] mplier, acc_q, dat_q;
  logic          hi_nz;

  assign sz_d    = !opc_w ? 2'd0 : rex_w ? 2'd3 : osz_ovr ? 2'd1 : 2'd2;
  assign bad_req = !opc_w && rex_pres && src_hi8;

  always_comb begin
    case (sz_d)
      2'd0:    begin opmask = 64'h0000_0000_0000_00FF; width_d = CW'(8);  end
      2'd1:    begin opmask = 64'h0000_0000_0000_FFFF; width_d = CW'(16); end
      2'd2:    begin opmask = 64'h0000_0000_FFFF_FFFF; width_d = CW'(32); end
      default: begin opmask = '1;                      width_d = CW'(64); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
      cnt     <= '0;
      sz_q    <= 2'd0;
      mcand   <= '0;
      mplier  <= '0;
      prod    <= '0;
      acc_q   <= '0;
      dat_q   <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      if (busy) begin
        if (mplier[0]) prod <= prod + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        if (bad_req) begin
          illegal <= 1'b1;
        end else begin
          busy   <= 1'b1;
          cnt    <= width_d;
          sz_q   <= sz_d;
          mcand  <= {{XW{1'b0}}, acc_in & opmask};
          mplier <= src_in & opmask;
          prod   <= '0;
          acc_q  <= acc_in;
          dat_q  <= dat_in;
        end
      end
    end
  end

  always_comb begin
    case (sz_q)
      2'd0: begin
        acc_out = {acc_q[63:16], prod[15:0]};
        dat_out = dat_q;
        hi_nz   = |prod[15:8];
      end
      2'd1: begin
        acc_out = {acc_q[63:16], prod[15:0]};
        dat_out = {dat_q[63:16], prod[31:16]};
        hi_nz   = |prod[31:16];
      end
      2'd2: begin
        acc_out = {32'd0, prod[31:0]};
        dat_out = {32'd0, prod[63:32]};
        hi_nz   = |prod[63:32];
      end
      default: begin
        acc_out = prod[63:0];
        dat_out = prod[127:64];
        hi_nz   = |prod[127:64];
      end
    endcase
  end

  assign acc_we   = done;
  assign dat_we   = done && (sz_q != 2'd0);
  assign flags_we = done;
  assign cf       = hi_nz;
  assign of       = hi_nz;
endmodule

// File: rtl/umul_xu_chk.sv
module umul_xu_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        illegal,
  input logic        dat_we,
  input logic        flags_we,
  input logic        acc_we,
  input logic        cf,
  input logic        of,
  input logic [63:0] acc_out
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_busy_to_done: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r5_byte_flags: assert property (@(posedge clk) disable iff (rst)
    (done && !dat_we) |-> (cf == (acc_out[15:8] != 8'd0)));
  a_r5_flags_agree: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (cf == of));
  a_r5_dat_we_in_done: assert property (@(posedge clk) disable iff (rst)
    dat_we |-> (done && acc_we));
  a_r7_illegal_idle: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!busy && !done));
  a_r10_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !illegal));
endmodule

bind umul_xu umul_xu_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .illegal(illegal),
  .dat_we(dat_we), .flags_we(flags_we), .acc_we(acc_we),
  .cf(cf), .of(of), .acc_out(acc_out)
);

// File: tb/umul_xu_test.sv
module umul_xu_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, opc_w = 1'b0, osz_ovr = 1'b0, rex_w = 1'b0, rex_pres = 1'b0, src_hi8 = 1'b0;
  logic [63:0] acc_in = '0, dat_in = '0, src_in = '0;
  logic busy, done, illegal, acc_we, dat_we, flags_we, cf, of;
  logic [63:0] acc_out, dat_out;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  bit m_busy = 0, m_done = 0, m_ill = 0, m_ign = 0;
  int m_left = 0, m_w = 8, m_elapsed = 0;
  logic [63:0] e_acc, e_dat;
  bit e_dwe, e_flag;
  string e_tag = "R1";

  always #10 clk = ~clk;

  umul_xu uut (
    .clk(clk), .rst(rst), .start(start), .opc_w(opc_w), .osz_ovr(osz_ovr),
    .rex_w(rex_w), .rex_pres(rex_pres), .src_hi8(src_hi8),
    .acc_in(acc_in), .dat_in(dat_in), .src_in(src_in),
    .busy(busy), .done(done), .illegal(illegal),
    .acc_out(acc_out), .dat_out(dat_out),
    .acc_we(acc_we), .dat_we(dat_we), .flags_we(flags_we), .cf(cf), .of(of)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_load();
    logic [127:0] p;
    logic [63:0] msk, hi;
    if (!opc_w) m_w = 8; else if (rex_w) m_w = 64; else if (osz_ovr) m_w = 16; else m_w = 32;
    msk = (m_w == 64) ? '1 : ((64'd1 << m_w) - 64'd1);
    p = {64'd0, acc_in & msk} * {64'd0, src_in & msk};
    hi = 64'(p >> m_w);
    e_flag = (hi != 0);
    case (m_w)
      8:  begin e_acc = {acc_in[63:16], p[15:0]}; e_dat = dat_in; e_dwe = 0; e_tag = "R1"; end
      16: begin e_acc = {acc_in[63:16], p[15:0]}; e_dat = {dat_in[63:16], p[31:16]}; e_dwe = 1; e_tag = "R2"; end
      32: begin e_acc = {32'd0, p[31:0]}; e_dat = {32'd0, p[63:32]}; e_dwe = 1; e_tag = "R3"; end
      default: begin e_acc = p[63:0]; e_dat = p[127:64]; e_dwe = 1; e_tag = "R4"; end
    endcase
  endtask

  always @(posedge clk) begin
    #5;
    cyc++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_ill = 0; m_ign = 0;
    end else begin
      m_done = 0; m_ill = 0;
      if (m_busy) begin
        if (start) m_ign = 1;
        m_left--; m_elapsed++;
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
      end else if (start) begin
        if (!opc_w && rex_pres && src_hi8) m_ill = 1;
        else begin m_busy = 1; m_left = 0; model_load(); m_left = m_w; m_elapsed = 0; m_ign = 0; end
      end
    end
    chk(busy == m_busy, rst ? "R10" : "R8", busy, m_busy);
    chk(done == m_done, rst ? "R10" : "R8", done, m_done);
    chk(illegal == m_ill, rst ? "R10" : "R7", illegal, m_ill);
    if (m_done) begin
      chk(m_elapsed == m_w, "R6", m_elapsed, m_w);
      chk(acc_out == e_acc, e_tag, acc_out, e_acc);
      chk(dat_out == e_dat, e_tag, dat_out, e_dat);
      chk(dat_we == e_dwe, e_tag, dat_we, e_dwe);
      chk(cf == e_flag && of == e_flag, "R5", {cf, of}, {e_flag, e_flag});
      chk(acc_we && flags_we, "R5", {acc_we, flags_we}, 2'b11);
      if (m_ign) chk(acc_out == e_acc && dat_out == e_dat, "R9", acc_out, e_acc);
    end else if (!rst) begin
      chk(!acc_we && !dat_we && !flags_we, "R5", {acc_we, dat_we, flags_we}, 3'b000);
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic launch(input bit w, input bit osz, input bit rw, input bit rp, input bit h8,
                        input logic [63:0] a, input logic [63:0] d, input logic [63:0] s);
    @(negedge clk);
    opc_w = w; osz_ovr = osz; rex_w = rw; rex_pres = rp; src_hi8 = h8;
    acc_in = a; dat_in = d; src_in = s; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic op(input bit w, input bit osz, input bit rw, input bit rp, input bit h8,
                    input logic [63:0] a, input logic [63:0] d, input logic [63:0] s);
    launch(w, osz, rw, rp, h8, a, d, s);
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 byte form, flags set and clear
    op(0, 0, 0, 0, 0, 64'hAAAA_BBBB_CCCC_DDFF, 64'h1234, 64'hFF);
    op(0, 0, 0, 0, 0, 64'h1111_2222_3333_4403, 64'h5678, 64'h05);
    op(0, 0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FF10, 64'h9, 64'h10);
    // R2 word
    op(1, 1, 0, 0, 0, 64'hDEAD_BEEF_CAFE_FFFF, 64'h0123_4567_89AB_CDEF, 64'hFFFF);
    op(1, 1, 0, 0, 0, 64'h5555_0000_0000_0010, 64'h7777_0000_0000_0000, 64'h20);
    // R3 dword with junk above
    op(1, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF);
    op(1, 0, 0, 1, 0, 64'h9999_9999_0000_1000, 64'h1, 64'h3);
    // R4 qword, R6 rex_w over osz
    op(1, 0, 1, 1, 0, '1, 64'h0, '1);
    op(1, 1, 1, 1, 0, 64'h8000_0000_0000_0000, 64'h0, 64'h2);
    op(1, 0, 1, 1, 0, 64'h0, 64'h42, 64'h1234_5678_9ABC_DEF0);
    // R7 illegal byte request
    op(0, 0, 0, 1, 1, 64'h12, 64'h0, 64'h34);
    // R9 start while busy
    launch(1, 0, 1, 1, 0, 64'h0000_0001_0000_0003, 64'h0, 64'h7);
    repeat (5) @(negedge clk);
    launch(0, 0, 0, 0, 0, 64'hFF, 64'h0, 64'hFF);
    while (m_busy) @(negedge clk);
    @(negedge clk);
    // R10 reset mid operation
    launch(1, 0, 0, 0, 0, 64'h1234_5678, 64'h0, 64'h9ABC_DEF0);
    repeat (4) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      op($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), 0,
         {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule